// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds a small bank of hardware semaphore latches that two independent ports share, called here the left side and the right side. Each semaphore stands for one shared resource. A side that wants the resource writes a zero to that semaphore. It then reads the semaphore back to learn whether it now holds the token. When it is done it writes a one to give the token back. Each side has its own strobes and its own readback path. A select input on each side separates semaphore traffic from any other traffic on the same strobes.

A side that asks for a semaphore while the other side holds it does not take it. Its request is kept as pending. When the holder writes a one, the token goes straight to the waiting side, so no second write is needed. If both sides ask for a free semaphore in the same clock cycle, the left side gets it and the right side's request is kept as pending.

Top module: `sem_unit`

## Requirements
- R1: No semaphore is held by both sides at once. When both sides read the same index in the same cycle, the two readbacks are never both zero.
- R2: A left write of data 0 to a free semaphore gives that semaphore to the left side from the next cycle on.
- R3: A right write of data 0 to a free semaphore gives that semaphore to the right side from the next cycle on.
- R4: A write of data 1 by the side that holds a semaphore takes the token away from that side. With no pending request from the other side, the semaphore becomes free.
- R5: A write of data 0 by the side that does not hold the semaphore leaves the holder unchanged.
- R6: A rejected data-0 write is kept as a pending request. When the holder writes a 1, the token passes directly to the waiting side.
- R7: When both sides write data 0 to the same free semaphore in the same cycle, the left side wins. The right request is kept pending and is granted on the left release.
- R8: A write of data 1 by a side that does not hold the semaphore only cancels that side's own pending request. The holder keeps the token, and a later release leaves the semaphore free.
- R9: Readback is registered. A read strobe with the select high sets the read data in the next cycle to all zeros if the reading side holds the addressed semaphore, and to all ones otherwise. Every bit carries the same value. The read data keeps its value in all other cycles.
- R10: A synchronous active-high reset frees every semaphore, clears every pending request and sets both read data outputs to all ones.
- R11: The write and read strobes of a side have no effect while that side's select is low.
- R12: A write addressed to one semaphore index does not change the holder of any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left semaphore select |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_idx | input | IDX_W (3) | Left semaphore index |
| l_wbit | input | 1 | Left write data: 0 asks for the token, 1 gives it back |
| l_rdata | output | DATA_W (8) | Left readback: all zeros when the left side holds the semaphore |
| r_sel | input | 1 | Right semaphore select |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_idx | input | IDX_W (3) | Right semaphore index |
| r_wbit | input | 1 | Right write data: 0 asks for the token, 1 gives it back |
| r_rdata | output | DATA_W (8) | Right readback: all zeros when the right side holds the semaphore |

## Verification
The properties assume that the strobes, index and data bit are stable, known values at each clock edge. They also assume that each side issues at most one write per cycle, so a side never asks for and gives back a token in the same cycle. The bench drives every input on the falling edge, with one operation per task step, and it never leaves an index unknown while a strobe is high. Same-cycle cases are produced on purpose: both sides asking at once, and a release that meets a request from the other side. These cases exercise the tie rule and the hand-off path.

// File: rtl/sem_pkg.sv
package sem_pkg;

    // Who holds a semaphore
    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_LEFT  = 2'd1,
        HOLD_RIGHT = 2'd2
    } holder_e;

    // Operation one side applies to one semaphore in a cycle
    typedef struct packed {
        logic ask;   // data-0 write
        logic give;  // data-1 write
    } sem_op_t;

    // State of one semaphore latch
    typedef struct packed {
        holder_e holder;
        logic    wait_l;
        logic    wait_r;
    } sem_state_t;

    localparam sem_state_t SEM_IDLE = '{holder: HOLD_NONE, wait_l: 1'b0, wait_r: 1'b0};

    // Next state of one latch. Pending requests of the non-holder are
    // updated first, then a free or freed latch is granted with the
    // left side taking priority.
    function automatic sem_state_t sem_step(sem_state_t cur, sem_op_t op_l, sem_op_t op_r);
        sem_state_t nxt;
        logic       wl;
        logic       wr;
        logic       opens;
        wl = 1'b0;
        wr = 1'b0;
        if (cur.holder != HOLD_LEFT) begin
            wl = (cur.wait_l | op_l.ask) & ~op_l.give;
        end
        if (cur.holder != HOLD_RIGHT) begin
            wr = (cur.wait_r | op_r.ask) & ~op_r.give;
        end
        opens = (cur.holder == HOLD_NONE)
              | ((cur.holder == HOLD_LEFT)  & op_l.give)
              | ((cur.holder == HOLD_RIGHT) & op_r.give);
        nxt        = cur;
        nxt.wait_l = wl;
        nxt.wait_r = wr;
        if (opens) begin
            if (wl) begin
                nxt.holder = HOLD_LEFT;
                nxt.wait_l = 1'b0;
            end else if (wr) begin
                nxt.holder = HOLD_RIGHT;
                nxt.wait_r = 1'b0;
            end else begin
                nxt.holder = HOLD_NONE;
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
    import sem_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = 3
) (
    input  logic                      sel,
    input  logic                      wr,
    input  logic [IDX_W-1:0]          idx,
    input  logic                      wbit,
    output sem_op_t [NUM_SEM-1:0]     ops
);

    logic strobe;
    assign strobe = sel & wr;

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
        logic hit;
        assign hit         = strobe & (idx == IDX_W'(g));
        assign ops[g].ask  = hit & ~wbit;
        assign ops[g].give = hit & wbit;
    end

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sem_op_t op_l,
    input  sem_op_t op_r,
    output logic    held_l,
    output logic    held_r
);

    sem_state_t st_q;
    sem_state_t st_d;

    always_comb begin
        st_d = sem_step(st_q, op_l, op_r);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEM_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_l = (st_q.holder == HOLD_LEFT);
    assign held_r = (st_q.holder == HOLD_RIGHT);

endmodule

// File: rtl/sem_readback.sv
module sem_readback #(
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = 3,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  logic               rd,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] held,
    output logic [DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '1;
        end else if (sel && rd) begin
            rdata_q <= {DATA_W{~held[idx]}};
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/sem_unit.sv
module sem_unit
    import sem_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [IDX_W-1:0]  l_idx,
    input  logic              l_wbit,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic              r_wbit,
    output logic [DATA_W-1:0] r_rdata
);

    sem_op_t [NUM_SEM-1:0] ops_l;
    sem_op_t [NUM_SEM-1:0] ops_r;
    logic    [NUM_SEM-1:0] own_l;
    logic    [NUM_SEM-1:0] own_r;

    sem_port_decode #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) dec_l_i (
        .sel(l_sel), .wr(l_wr), .idx(l_idx), .wbit(l_wbit), .ops(ops_l)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) dec_r_i (
        .sel(r_sel), .wr(r_wr), .idx(r_idx), .wbit(r_wbit), .ops(ops_r)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        sem_cell cell_i (
            .clk   (clk),
            .rst   (rst),
            .op_l  (ops_l[g]),
            .op_r  (ops_r[g]),
            .held_l(own_l[g]),
            .held_r(own_r[g])
        );
    end

    sem_readback #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) rb_l_i (
        .clk(clk), .rst(rst), .sel(l_sel), .rd(l_rd), .idx(l_idx),
        .held(own_l), .rdata(l_rdata)
    );

    sem_readback #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) rb_r_i (
        .clk(clk), .rst(rst), .sel(r_sel), .rd(r_rd), .idx(r_idx),
        .held(own_r), .rdata(r_rdata)
    );

endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               l_sel,
    input logic               l_wr,
    input logic               l_rd,
    input logic [IDX_W-1:0]   l_idx,
    input logic               l_wbit,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_sel,
    input logic               r_wr,
    input logic               r_rd,
    input logic [IDX_W-1:0]   r_idx,
    input logic               r_wbit,
    input logic [DATA_W-1:0]  r_rdata,
    input logic [NUM_SEM-1:0] own_l,
    input logic [NUM_SEM-1:0] own_r
);

    logic l_ask;
    logic l_give;
    logic r_ask;
    logic r_give;
    assign l_ask  = l_sel && l_wr && !l_wbit;
    assign l_give = l_sel && l_wr && l_wbit;
    assign r_ask  = r_sel && r_wr && !r_wbit;
    assign r_give = r_sel && r_wr && r_wbit;

    // R1
    excl_read_chk: assert property (@(posedge clk) disable iff (rst)
        (l_sel && l_rd && r_sel && r_rd && l_idx == r_idx) |=> !(l_rdata[0] == 1'b0 && r_rdata[0] == 1'b0));

    // R2
    left_grab_chk: assert property (@(posedge clk) disable iff (rst)
        (l_ask && !own_l[l_idx] && !own_r[l_idx]) |=> own_l[$past(l_idx)]);

    // R4
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (l_give && own_l[l_idx]) |=> !own_l[$past(l_idx)]);

    // R5
    keep_holder_chk: assert property (@(posedge clk) disable iff (rst)
        (l_ask && own_r[l_idx] && !(r_give && r_idx == l_idx)) |=> own_r[$past(l_idx)]);

    // R9
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        (l_sel && l_rd) |=> (l_rdata == {DATA_W{!$past(own_l[l_idx])}}));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(r_sel && r_rd) |=> $stable(r_rdata));

    // R10
    reset_free_chk: assert property (@(posedge clk)
        rst |=> (own_l == '0 && own_r == '0 && l_rdata == '1 && r_rdata == '1));

endmodule

bind sem_unit sem_unit_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_wr(l_wr), .l_rd(l_rd), .l_idx(l_idx), .l_wbit(l_wbit), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_wr(r_wr), .r_rd(r_rd), .r_idx(r_idx), .r_wbit(r_wbit), .r_rdata(r_rdata),
    .own_l(own_l), .own_r(own_r)
);

// File: tb/sem_unit_tb_top.sv
module sem_unit_tb_top;

    localparam int NS = 8;
    localparam int DW = 8;
    localparam logic [DW-1:0] HOLD = '0;
    localparam logic [DW-1:0] NOTH = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          l_sel = 0, l_wr = 0, l_rd = 0, l_wbit = 0;
    logic [2:0]    l_idx = '0;
    logic          r_sel = 0, r_wr = 0, r_rd = 0, r_wbit = 0;
    logic [2:0]    r_idx = '0;
    logic [DW-1:0] l_rdata;
    logic [DW-1:0] r_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sem_unit #(.NUM_SEM(NS), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .l_sel(l_sel), .l_wr(l_wr), .l_rd(l_rd), .l_idx(l_idx), .l_wbit(l_wbit), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_wr(r_wr), .r_rd(r_rd), .r_idx(r_idx), .r_wbit(r_wbit), .r_rdata(r_rdata)
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // side 0 = left, 1 = right; one write in one cycle
    task automatic wr1(bit side, int idx, bit d);
        @(negedge clk);
        if (side == 0) begin l_sel = 1; l_wr = 1; l_idx = 3'(idx); l_wbit = d; end
        else           begin r_sel = 1; r_wr = 1; r_idx = 3'(idx); r_wbit = d; end
        @(negedge clk);
        l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
    endtask

    task automatic wr_both(int li, bit ld, int ri, bit rd_);
        @(negedge clk);
        l_sel = 1; l_wr = 1; l_idx = 3'(li); l_wbit = ld;
        r_sel = 1; r_wr = 1; r_idx = 3'(ri); r_wbit = rd_;
        @(negedge clk);
        l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
    endtask

    task automatic rd1(bit side, int idx, output logic [DW-1:0] v);
        @(negedge clk);
        if (side == 0) begin l_sel = 1; l_rd = 1; l_idx = 3'(idx); end
        else           begin r_sel = 1; r_rd = 1; r_idx = 3'(idx); end
        @(negedge clk);
        v = (side == 0) ? l_rdata : r_rdata;
        l_sel = 0; l_rd = 0; r_sel = 0; r_rd = 0;
    endtask

    task automatic rd_both(int idx, output logic [DW-1:0] vl, output logic [DW-1:0] vr);
        @(negedge clk);
        l_sel = 1; l_rd = 1; l_idx = 3'(idx);
        r_sel = 1; r_rd = 1; r_idx = 3'(idx);
        @(negedge clk);
        vl = l_rdata; vr = r_rdata;
        l_sel = 0; l_rd = 0; r_sel = 0; r_rd = 0;
    endtask

    task automatic t_reset_state();
        logic [DW-1:0] v;
        check("R10 left rdata after reset", l_rdata, NOTH);
        check("R10 right rdata after reset", r_rdata, NOTH);
        rd1(0, 0, v); check("R10 sem0 free for left", v, NOTH);
        rd1(1, 7, v); check("R10 sem7 free for right", v, NOTH);
    endtask

    task automatic t_left_grab();
        logic [DW-1:0] a, b;
        do_reset();
        wr1(0, 1, 0);
        rd_both(1, a, b);
        check("R2 left holds", a, HOLD);
        check("R2 right not holder", b, NOTH);
        check("R1 not both zero", {7'd0, a[0] | b[0]}, 8'd1);
    endtask

    task automatic t_right_grab_release();
        logic [DW-1:0] v;
        do_reset();
        wr1(1, 6, 0);
        rd1(1, 6, v); check("R3 right holds", v, HOLD);
        wr1(1, 6, 1);
        rd1(1, 6, v); check("R4 right freed", v, NOTH);
        wr1(0, 6, 0);
        rd1(0, 6, v); check("R4 free after release, left grabs", v, HOLD);
    endtask

    task automatic t_contest_handoff();
        logic [DW-1:0] a, b;
        do_reset();
        wr1(0, 2, 0);
        wr1(1, 2, 0);
        rd_both(2, a, b);
        check("R5 left still holds", a, HOLD);
        check("R5 right refused", b, NOTH);
        wr1(0, 2, 1);
        rd_both(2, a, b);
        check("R6 token passed to right", b, HOLD);
        check("R6 left released", a, NOTH);
    endtask

    task automatic t_release_meets_ask();
        logic [DW-1:0] v;
        do_reset();
        wr1(0, 5, 0);
        wr_both(5, 1, 5, 0);
        rd1(1, 5, v); check("R6 same-cycle release and ask", v, HOLD);
    endtask

    task automatic t_tie();
        logic [DW-1:0] a, b;
        do_reset();
        wr_both(3, 0, 3, 0);
        rd_both(3, a, b);
        check("R7 left wins tie", a, HOLD);
        check("R7 right loses tie", b, NOTH);
        wr1(0, 3, 1);
        rd1(1, 3, b); check("R7 right pending granted", b, HOLD);
    endtask

    task automatic t_cancel();
        logic [DW-1:0] a, b;
        do_reset();
        wr1(0, 4, 0);
        wr1(1, 4, 0);
        wr1(1, 4, 1);
        rd1(0, 4, a); check("R8 holder unchanged by cancel", a, HOLD);
        wr1(0, 4, 1);
        rd_both(4, a, b);
        check("R8 cancelled request not granted", b, NOTH);
        check("R8 left released", a, NOTH);
    endtask

    task automatic t_hold_readback();
        logic [DW-1:0] v;
        do_reset();
        wr1(0, 0, 0);
        rd1(0, 0, v); check("R9 readback zero", v, HOLD);
        wr1(0, 0, 1);
        @(negedge clk); @(negedge clk);
        check("R9 rdata held without read", l_rdata, HOLD);
        rd1(0, 0, v); check("R9 readback ones after release", v, NOTH);
    endtask

    task automatic t_select_low();
        logic [DW-1:0] v;
        do_reset();
        @(negedge clk);
        l_sel = 0; l_wr = 1; l_idx = 3'd1; l_wbit = 0;
        @(negedge clk);
        l_wr = 0;
        rd1(0, 1, v); check("R11 write ignored without select", v, NOTH);
        wr1(0, 1, 0);
        @(negedge clk);
        l_sel = 0; l_rd = 1; l_idx = 3'd1;
        @(negedge clk);
        check("R11 read ignored without select", l_rdata, NOTH);
        l_rd = 0;
        @(negedge clk);
        l_sel = 0; l_wr = 1; l_idx = 3'd1; l_wbit = 1;
        @(negedge clk);
        l_wr = 0;
        rd1(0, 1, v); check("R11 release ignored without select", v, HOLD);
    endtask

    task automatic t_independent();
        logic [DW-1:0] v;
        do_reset();
        wr1(0, 3, 0);
        wr1(1, 4, 0);
        rd1(0, 5, v); check("R12 idx5 untouched left", v, NOTH);
        rd1(1, 5, v); check("R12 idx5 untouched right", v, NOTH);
        wr1(0, 3, 1);
        rd1(1, 4, v); check("R12 idx4 kept by right", v, HOLD);
        rd1(0, 4, v); check("R12 idx4 not left", v, NOTH);
    endtask

    task automatic t_reset_clears_pending();
        logic [DW-1:0] v;
        do_reset();
        wr1(0, 2, 0);
        wr1(1, 2, 0);
        do_reset();
        rd1(0, 2, v); check("R10 sem freed by reset", v, NOTH);
        wr1(0, 2, 0);
        wr1(0, 2, 1);
        rd1(1, 2, v); check("R10 pending cleared by reset", v, NOTH);
    endtask

    initial begin
        fork
            begin
                @(negedge clk); @(negedge clk);
                rst = 1'b0;
                t_reset_state();
                t_left_grab();
                t_right_grab_release();
                t_contest_handoff();
                t_release_meets_ask();
                t_tie();
                t_cancel();
                t_hold_readback();
                t_select_low();
                t_independent();
                t_reset_clears_pending();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule